// File: doc/BRIEF.md
# Host Prefetch Queue Tracker

This block lets a coprocessor follow the instruction stream of a host processor that prefetches its opcodes into a private queue. The host queue cannot be read directly, so the tracker builds a shadow copy of it from the outside. It watches the host's code fetch cycles and writes each fetched byte into a small local ring. It then removes bytes from that ring whenever the host's two queue-status pins report that the host took a byte. When the status pins report that the host discarded its queue, the ring is flushed.

When the host takes the first byte of an instruction and that byte carries the escape prefix, the tracker holds the byte's low three bits. The next byte the host takes is the addressing byte. The two bytes together form an 11-bit coprocessor opcode, which the tracker reports for one cycle. The tracker also decodes from the addressing byte whether the instruction works on memory. If it does, the tracker captures the address of the next host read cycle, which is the dummy read that names the operand.

The host's bus width is read once from the high-byte-enable/status pin on the first clock after reset. A 16-bit host gives a six-byte queue that can take two bytes per fetch. An 8-bit host gives a four-byte queue that takes one byte per fetch.

Top module: `host_queue_tracker`

## Requirements
- R1: After reset, `q_level` is 0 and `esc_valid`, `opd_addr_valid` and `underflow_err` are all 0.
- R2: On the first rising edge after `rst_n` goes high, `bhe_status_n` is sampled. Low selects a 16-bit host (`host_wide`=1, capacity 6). High selects an 8-bit host (`host_wide`=0, capacity 4). The value then holds until the next reset.
- R3: Fetch lanes. A 16-bit host fetch at an even address (`fetch_addr0`=0) queues `fetch_data[7:0]` and then `fetch_data[15:8]`. A 16-bit fetch at an odd address queues only `fetch_data[15:8]`. An 8-bit host fetch queues only `fetch_data[7:0]`.
- R4: `qs` code 00 leaves the queue unchanged. Codes 01 (first opcode byte) and 11 (later byte) each remove one byte from the head, oldest first. Code 10 empties the queue.
- R5: If a flush (`qs`=10) and a fetch fall in the same cycle, the queue afterwards holds only the newly fetched bytes.
- R6: Bytes that would take the queue beyond its capacity (6 or 4) are discarded, and `q_level` stops at the capacity.
- R7: A byte taken with `qs`=01 whose bits [7:3] are 11011 starts an escape. The next byte taken with `qs`=11 completes it. On the edge where the second byte is taken, `esc_valid` rises for exactly one cycle, and `esc_opcode` = {first[2:0], second[7:0]}.
- R8: A first byte whose bits [7:3] are not 11011 produces no `esc_valid`. A `qs`=11 take that has no escape pending also produces no `esc_valid`.
- R9: `esc_needs_mem` is 1 unless bits [7:6] of the addressing byte are 11, which marks a register-only form.
- R10: After a memory-form escape, the first `rd_stb` cycle loads `rd_addr` into `opd_addr`, and `opd_addr_valid` is 1 for the cycle after that edge. Later read strobes are not captured. A register-only escape captures no read address.
- R11: A take (`qs`=01 or 11) while the queue is empty removes nothing and sets `underflow_err`. The flag stays set until reset.
- R12: When a take and a fetch fall in the same cycle, the take is served from the bytes already queued, and the new bytes are appended after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bhe_status_n | input | 1 | Host high-byte-enable/status pin, sampled once after reset |
| qs | input | 2 | Host queue-status code |
| fetch_stb | input | 1 | Host code fetch completes with data this cycle |
| fetch_addr0 | input | 1 | Address bit 0 of the fetch |
| fetch_data | input | 16 | Host data bus during the fetch |
| rd_stb | input | 1 | Host memory read cycle completes this cycle |
| rd_addr | input | 20 | Address of that read |
| host_wide | output | 1 | 1 when a 16-bit host was detected |
| q_level | output | 3 | Bytes currently held in the shadow queue |
| esc_valid | output | 1 | One-cycle pulse: escape instruction recognised |
| esc_opcode | output | 11 | Escape opcode: low three bits of the first byte, then the addressing byte |
| esc_needs_mem | output | 1 | The escape instruction has a memory operand |
| opd_addr | output | 20 | Captured operand address |
| opd_addr_valid | output | 1 | One-cycle pulse: opd_addr was just loaded |
| underflow_err | output | 1 | Sticky: a take was reported with the queue empty |

## Verification
The assertions rely on the status code and the fetch strobe being valid on every clock after reset. They also rely on the host never reporting a take that the shadow queue has not seen fetched, except in the deliberate underflow case. The bench holds its inputs steady between edges, always fetches before it reports takes, and keeps each read strobe apart from the escape that arms it. Underflow and overflow are driven only in the directed cases that test them.

// File: rtl/qt_pkg.sv
// Shared definitions for the host prefetch queue tracker.
// Assumes byte-wide opcodes and a two-bit queue-status encoding.
package qt_pkg;
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qs_code_e;

    localparam int          BYTE_W     = 8;
    localparam int          OPC_W      = 11;
    localparam logic [4:0]  ESC_PREFIX = 5'b11011;
    localparam logic [1:0]  MOD_REG    = 2'b11;
endpackage

// File: rtl/qt_fetch_lanes.sv
// Fetch lane selector: turns one watched fetch cycle into zero, one or two
// bytes for the shadow queue, in the order the host queues them.
// Assumes the bus width mode is already settled.
module qt_fetch_lanes
    import qt_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic              wide,
    input  logic              fetch_stb,
    input  logic              fetch_addr0,
    input  logic [BUS_W-1:0]  fetch_data,
    output logic [1:0]        push_n,
    output logic [BYTE_W-1:0] push_b0,
    output logic [BYTE_W-1:0] push_b1
);
    localparam int HI_LSB = BUS_W - BYTE_W;

    // Choose the byte count and the lane order for this fetch.
    always_comb begin
        push_n  = 2'd0;
        push_b0 = fetch_data[BYTE_W-1:0];
        push_b1 = fetch_data[HI_LSB +: BYTE_W];
        if (fetch_stb) begin
            if (!wide) begin
                push_n = 2'd1;
            end else if (fetch_addr0) begin
                push_n  = 2'd1;
                push_b0 = fetch_data[HI_LSB +: BYTE_W];
            end else begin
                push_n = 2'd2;
            end
        end
    end
endmodule

// File: rtl/qt_shadow_fifo.sv
// Shadow byte queue: a ring of MAX_DEPTH bytes with a run-time capacity
// (MAX_DEPTH or NARROW_DEPTH). Takes up to two bytes and gives one per cycle.
// A flush empties the ring before the same cycle's bytes are written.
// A take on an empty ring sets a sticky error. Excess bytes are dropped.
module qt_shadow_fifo
    import qt_pkg::*;
#(
    parameter int MAX_DEPTH    = 6,
    parameter int NARROW_DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wide,
    input  logic                             flush,
    input  logic                             pop_req,
    input  logic [1:0]                       push_n,
    input  logic [BYTE_W-1:0]                push_b0,
    input  logic [BYTE_W-1:0]                push_b1,
    output logic [BYTE_W-1:0]                head,
    output logic                             pop_ok,
    output logic [$clog2(MAX_DEPTH+1)-1:0]   level,
    output logic                             underflow_err
);
    localparam int PTR_W = $clog2(MAX_DEPTH);
    localparam int CNT_W = $clog2(MAX_DEPTH+1);

    logic [BYTE_W-1:0] store [MAX_DEPTH];
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    int limit, base_cnt, base_rd, free_slots, accept, slot0, slot1;

    function automatic int wrap_idx(input int v);
        return (v >= MAX_DEPTH) ? v - MAX_DEPTH : v;
    endfunction

    // Work out the next pointer, the count and the write slots.
    always_comb begin
        limit      = wide ? MAX_DEPTH : NARROW_DEPTH;
        pop_ok     = pop_req && !flush && (cnt_q != '0);
        base_cnt   = flush ? 0 : int'(cnt_q) - (pop_ok ? 1 : 0);
        base_rd    = flush ? 0 : wrap_idx(int'(rd_ptr) + (pop_ok ? 1 : 0));
        free_slots = limit - base_cnt;
        accept     = (int'(push_n) > free_slots) ? free_slots : int'(push_n);
        slot0      = wrap_idx(base_rd + base_cnt);
        slot1      = wrap_idx(slot0 + 1);
    end

    generate
        for (genvar g = 0; g < MAX_DEPTH; g++) begin : g_slot
            logic [BYTE_W-1:0] byte_q;
            // Load this slot when one of the accepted bytes lands on it.
            always_ff @(posedge clk) begin
                if (accept >= 1 && slot0 == g) begin
                    byte_q <= push_b0;
                end else if (accept >= 2 && slot1 == g) begin
                    byte_q <= push_b1;
                end
            end
            assign store[g] = byte_q;
        end
    endgenerate

    // Advance the read pointer and the count, and record any underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr        <= '0;
            cnt_q         <= '0;
            underflow_err <= 1'b0;
        end else begin
            rd_ptr <= PTR_W'(base_rd);
            cnt_q  <= CNT_W'(base_cnt + accept);
            if (pop_req && !flush && cnt_q == '0) begin
                underflow_err <= 1'b1;
            end
        end
    end

    assign head  = store[rd_ptr];
    assign level = cnt_q;

    p_level_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= limit);
    p_flush_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && push_n == 2'd0) |=> (cnt_q == '0));
    p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    p_empty_take_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !flush && cnt_q == '0 && push_n == 2'd0) |=> (cnt_q == '0));
endmodule

// File: rtl/qt_esc_detect.sv
// Escape recogniser: watches the bytes taken from the shadow queue, holds
// an escape first byte, and completes the opcode on the next later-byte take.
// Assumes first_try marks every first-byte status, taken or not.
module qt_esc_detect
    import qt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              first_try,
    input  logic              first_pop,
    input  logic              next_pop,
    input  logic [BYTE_W-1:0] head,
    output logic              fire,
    output logic              fire_mem,
    output logic              esc_valid,
    output logic [OPC_W-1:0]  esc_opcode,
    output logic              esc_needs_mem
);
    logic       pend_q;
    logic [2:0] low3_q;

    // Complete an escape when its addressing byte is taken.
    always_comb begin
        fire     = next_pop && pend_q;
        fire_mem = fire && (head[7:6] != MOD_REG);
    end

    // Track whether an escape first byte is waiting for its addressing byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            low3_q <= '0;
        end else if (flush) begin
            pend_q <= 1'b0;
        end else if (first_try) begin
            pend_q <= first_pop && (head[7:3] == ESC_PREFIX);
            low3_q <= head[2:0];
        end else if (fire) begin
            pend_q <= 1'b0;
        end
    end

    // Register the opcode and its memory flag as a one-cycle report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esc_valid     <= 1'b0;
            esc_opcode    <= '0;
            esc_needs_mem <= 1'b0;
        end else begin
            esc_valid <= fire;
            if (fire) begin
                esc_opcode    <= {low3_q, head};
                esc_needs_mem <= fire_mem;
            end
        end
    end

    p_esc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |=> !esc_valid);
    p_esc_needs_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (next_pop && !pend_q) |=> !esc_valid);
endmodule

// File: rtl/qt_operand_capture.sv
// Operand address capture: armed by a memory-form escape, it loads the
// address of the next host read cycle and reports it for one cycle.
// Assumes the host's dummy read follows the escape report.
module qt_operand_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              fire_mem,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] opd_addr,
    output logic              opd_addr_valid
);
    logic armed_q;

    // Arm on a memory escape, then capture and disarm on the first read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q        <= 1'b0;
            opd_addr       <= '0;
            opd_addr_valid <= 1'b0;
        end else begin
            opd_addr_valid <= armed_q && rd_stb;
            if (armed_q && rd_stb) begin
                opd_addr <= rd_addr;
            end
            if (fire) begin
                armed_q <= fire_mem;
            end else if (rd_stb) begin
                armed_q <= 1'b0;
            end
        end
    end

    p_capture_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        opd_addr_valid |-> $past(rd_stb));
endmodule

// File: rtl/host_queue_tracker.sv
// Host prefetch queue tracker top level. Samples the host bus width once
// after reset, mirrors the host opcode queue from the fetch cycles and the
// queue-status codes, reports escape opcodes, and captures operand addresses.
// Assumes every input is synchronous to clk.
module host_queue_tracker
    import qt_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int BUS_W        = 16,
    parameter int WIDE_DEPTH   = 6,
    parameter int NARROW_DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bhe_status_n,
    input  logic [1:0]                        qs,
    input  logic                              fetch_stb,
    input  logic                              fetch_addr0,
    input  logic [BUS_W-1:0]                  fetch_data,
    input  logic                              rd_stb,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic                              host_wide,
    output logic [$clog2(WIDE_DEPTH+1)-1:0]   q_level,
    output logic                              esc_valid,
    output logic [OPC_W-1:0]                  esc_opcode,
    output logic                              esc_needs_mem,
    output logic [ADDR_W-1:0]                 opd_addr,
    output logic                              opd_addr_valid,
    output logic                              underflow_err
);
    qs_code_e          qs_e;
    logic              mode_known_q;
    logic              flush, pop_req, pop_ok, first_try, first_pop, next_pop;
    logic [1:0]        push_n;
    logic [BYTE_W-1:0] push_b0, push_b1, head;
    logic              fire, fire_mem;

    // Latch the host bus width on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_known_q <= 1'b0;
            host_wide    <= 1'b0;
        end else if (!mode_known_q) begin
            mode_known_q <= 1'b1;
            host_wide    <= !bhe_status_n;
        end
    end

    // Decode the queue-status code into flush and take requests.
    always_comb begin
        qs_e      = qs_code_e'(qs);
        flush     = (qs_e == QS_FLUSH);
        first_try = (qs_e == QS_FIRST);
        pop_req   = (qs_e == QS_FIRST) || (qs_e == QS_NEXT);
        first_pop = pop_ok && (qs_e == QS_FIRST);
        next_pop  = pop_ok && (qs_e == QS_NEXT);
    end

    qt_fetch_lanes #(.BUS_W(BUS_W)) u_lanes (
        .wide        (host_wide),
        .fetch_stb   (fetch_stb),
        .fetch_addr0 (fetch_addr0),
        .fetch_data  (fetch_data),
        .push_n      (push_n),
        .push_b0     (push_b0),
        .push_b1     (push_b1)
    );

    qt_shadow_fifo #(.MAX_DEPTH(WIDE_DEPTH), .NARROW_DEPTH(NARROW_DEPTH)) u_fifo (
        .clk           (clk),
        .rst_n         (rst_n),
        .wide          (host_wide),
        .flush         (flush),
        .pop_req       (pop_req),
        .push_n        (push_n),
        .push_b0       (push_b0),
        .push_b1       (push_b1),
        .head          (head),
        .pop_ok        (pop_ok),
        .level         (q_level),
        .underflow_err (underflow_err)
    );

    qt_esc_detect u_esc (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .first_try     (first_try),
        .first_pop     (first_pop),
        .next_pop      (next_pop),
        .head          (head),
        .fire          (fire),
        .fire_mem      (fire_mem),
        .esc_valid     (esc_valid),
        .esc_opcode    (esc_opcode),
        .esc_needs_mem (esc_needs_mem)
    );

    qt_operand_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire           (fire),
        .fire_mem       (fire_mem),
        .rd_stb         (rd_stb),
        .rd_addr        (rd_addr),
        .opd_addr       (opd_addr),
        .opd_addr_valid (opd_addr_valid)
    );

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_known_q |=> $stable(host_wide));
    p_esc_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        esc_valid |-> ($past(qs) == QS_NEXT));
endmodule

// File: tb/tb_host_queue_tracker.sv
`timescale 1ns/1ps
module tb_host_queue_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bhe_status_n = 1'b1;
    logic [1:0]  qs = 2'b00;
    logic        fetch_stb = 1'b0;
    logic        fetch_addr0 = 1'b0;
    logic [15:0] fetch_data = '0;
    logic        rd_stb = 1'b0;
    logic [19:0] rd_addr = '0;
    logic        host_wide;
    logic [2:0]  q_level;
    logic        esc_valid;
    logic [10:0] esc_opcode;
    logic        esc_needs_mem;
    logic [19:0] opd_addr;
    logic        opd_addr_valid;
    logic        underflow_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    host_queue_tracker dut (
        .clk(clk), .rst_n(rst_n), .bhe_status_n(bhe_status_n), .qs(qs),
        .fetch_stb(fetch_stb), .fetch_addr0(fetch_addr0), .fetch_data(fetch_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .host_wide(host_wide),
        .q_level(q_level), .esc_valid(esc_valid), .esc_opcode(esc_opcode),
        .esc_needs_mem(esc_needs_mem), .opd_addr(opd_addr),
        .opd_addr_valid(opd_addr_valid), .underflow_err(underflow_err)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic bhe);
        rst_n = 1'b0; bhe_status_n = bhe;
        qs = 2'b00; fetch_stb = 1'b0; rd_stb = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 level after reset", q_level, 0);
        chk("R1 esc_valid after reset", esc_valid, 0);
        chk("R1 opd_addr_valid after reset", opd_addr_valid, 0);
        chk("R1 underflow_err after reset", underflow_err, 0);
        chk("R2 host_wide", host_wide, bhe ? 0 : 1);
    endtask

    task automatic fetch(input logic a0, input logic [15:0] d);
        fetch_stb = 1'b1; fetch_addr0 = a0; fetch_data = d;
        step();
        fetch_stb = 1'b0;
    endtask

    task automatic qop(input logic [1:0] c);
        qs = c;
        step();
        qs = 2'b00;
    endtask

    task automatic rd(input logic [19:0] a);
        rd_stb = 1'b1; rd_addr = a;
        step();
        rd_stb = 1'b0;
    endtask

    initial begin
        // Narrow host: lanes, capacity, flush, mode hold.
        do_reset(1'b1);
        bhe_status_n = 1'b0;
        step();
        chk("R2 mode holds after pin change", host_wide, 0);
        fetch(1'b0, 16'hEED8);
        fetch(1'b1, 16'h77C1);
        chk("R3 narrow one byte per fetch", q_level, 2);
        qop(2'b01);
        qop(2'b11);
        chk("R3 R7 narrow low lane escape", esc_valid, 1);
        chk("R3 narrow opcode", esc_opcode, 11'h0C1);
        chk("R9 register form", esc_needs_mem, 0);
        step();
        chk("R7 esc pulse one cycle", esc_valid, 0);
        for (int i = 0; i < 6; i++) fetch(1'b0, 16'h1234);
        chk("R6 narrow capacity", q_level, 4);
        qop(2'b00);
        chk("R4 idle keeps level", q_level, 4);
        qop(2'b10);
        chk("R4 flush empties", q_level, 0);

        // Wide host: capacity, odd-address lane, operand capture.
        do_reset(1'b0);
        for (int i = 0; i < 4; i++) fetch(1'b0, 16'hABCD);
        chk("R6 wide capacity", q_level, 6);
        qop(2'b10);
        fetch(1'b1, 16'hDD00);
        chk("R3 odd fetch one byte", q_level, 1);
        fetch(1'b1, 16'h06FF);
        qop(2'b01);
        qop(2'b11);
        chk("R3 R7 odd lane escape", esc_valid, 1);
        chk("R3 odd lane opcode", esc_opcode, 11'h506);
        chk("R9 memory form", esc_needs_mem, 1);
        rd(20'h12345);
        chk("R10 capture valid", opd_addr_valid, 1);
        chk("R10 captured address", opd_addr, 20'h12345);
        rd(20'h0ABCD);
        chk("R10 only first read", opd_addr_valid, 0);
        chk("R10 address held", opd_addr, 20'h12345);

        // Sweep every first byte against all four mod values.
        for (int b = 0; b < 256; b++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0]  sec;
                logic [19:0] a;
                bit          is_esc, mem;
                sec    = {m[1:0], 6'(b ^ 8'h15)};
                is_esc = (b[7:3] == 5'b11011);
                mem    = (m != 3);
                a      = 20'((b << 4) ^ (m << 12) ^ 20'h5A5A5);
                fetch(1'b0, {sec, b[7:0]});
                qop(2'b01);
                qop(2'b11);
                chk("R7 R8 sweep esc_valid", esc_valid, is_esc ? 1 : 0);
                if (is_esc) begin
                    chk("R7 sweep opcode", esc_opcode, ((b & 7) << 8) | sec);
                    chk("R9 sweep needs_mem", esc_needs_mem, mem ? 1 : 0);
                end
                chk("R4 sweep drained", q_level, 0);
                rd(a);
                chk("R10 sweep capture", opd_addr_valid, (is_esc && mem) ? 1 : 0);
                if (is_esc && mem) chk("R10 sweep address", opd_addr, a);
            end
        end

        // Later-byte takes with nothing pending.
        fetch(1'b0, 16'h12C0);
        qop(2'b11);
        chk("R8 stray later take", esc_valid, 0);
        qop(2'b11);
        chk("R8 stray later take 2", esc_valid, 0);
        chk("R4 later takes drain", q_level, 0);

        // Flush and fetch in the same cycle.
        fetch(1'b0, 16'h9999);
        qs = 2'b10; fetch(1'b0, 16'h05D9); qs = 2'b00;
        chk("R5 flush keeps new bytes", q_level, 2);
        qop(2'b01);
        qop(2'b11);
        chk("R5 new bytes in order", esc_opcode, 11'h105);
        chk("R5 escape valid", esc_valid, 1);
        rd(20'h00042);
        chk("R10 capture after flush case", opd_addr, 20'h00042);

        // Take and fetch in the same cycle.
        fetch(1'b1, 16'hD800);
        qs = 2'b01; fetch(1'b0, 16'hC3C2); qs = 2'b00;
        chk("R12 take from old bytes", q_level, 2);
        chk("R12 no underflow", underflow_err, 0);
        qop(2'b11);
        chk("R12 append after take", esc_opcode, 11'h0C2);
        qop(2'b10);
        qs = 2'b01; fetch(1'b0, 16'h1111); qs = 2'b00;
        chk("R12 empty take underflows", underflow_err, 1);
        chk("R12 fetched bytes kept", q_level, 2);

        // Sticky underflow.
        qop(2'b10);
        qop(2'b11);
        chk("R11 empty take keeps level", q_level, 0);
        repeat (3) step();
        chk("R11 flag sticky", underflow_err, 1);
        do_reset(1'b1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule